// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM organised as 16-bit words. It owns the select, serial clock and serial data-out pins and samples the data-in pin. A host issues one operation at a time on a command port: read a word, write a word, enable writes or disable writes. Each request carries an 8-bit word address and 16 bits of write data. The block produces the bit-level waveform for the operation and reports completion with a one-cycle strobe. A read returns its word on a held output.

A programmable divider sets the length of every waveform phase, so the serial clock rate comes from one input. A word write is a complete protected sequence. It enables writes, sends the data frame, waits for the device to signal that programming has finished, then disables writes again. Select drops for one phase between the steps.

The wait for completion is bounded. The device signals ready by driving data-in high while select is held with the clock idle. If that does not happen within a programmable number of phases, the operation still completes and raises an error flag.

Top module: `eeMwMaster`

## Requirements
- R1: After reset the block is idle, with select, serial clock, busy, done, error and read data all low. A request is accepted only while busy is low. Busy is high from the cycle after acceptance until done. A request presented while busy is ignored and does not change the device contents.
- R2: Every frame is sent most significant bit first and begins with a 1 start bit. A read frame follows it with opcode 10 and the 8 address bits. A data write frame follows it with opcode 01, the 8 address bits and the 16 data bits. Write-enable sends opcode 00 followed by eight 1s. Write-disable sends opcode 00 followed by eight 0s.
- R3: Each bit occupies three phases while select is high: clock low with data driven, clock high, clock low. Each phase lasts halfBitDiv+1 clock cycles. Data-out does not change while the serial clock is high.
- R4: A read sends its 11 command bits, then gives 16 more clock pulses. Data-in is sampled at the end of each high phase, MSB first. The result appears on rdData when done pulses.
- R5: rdData changes only when a read completes and holds its value through other operations.
- R6: A word write runs, in order: write-enable, deselect, 27-bit data frame, deselect, ready wait, deselect, write-disable, deselect.
- R7: During the ready wait, select is high and the serial clock stays low. Data-in is sampled once per phase, and a high value ends the wait.
- R8: If data-in stays low for readyTimeout samples (a value of 0 counts as 1), the wait ends. The remaining steps of the write still run, and timeoutErr is high when done pulses. Only a write can raise the error.
- R9: done is high for exactly one cycle per accepted request. timeoutErr holds its value until the next request is accepted.
- R10: Select stays low for at least one full phase before every frame or ready wait, and for at least one full phase after each one.
- R11: The serial clock is never high while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqOp | input | 2 | Operation: 0 read, 1 write, 2 write-enable, 3 write-disable |
| reqAddr | input | 8 | Word address |
| reqWdata | input | 16 | Word to write |
| halfBitDiv | input | 8 | Phase length minus one, in clock cycles |
| readyTimeout | input | 16 | Maximum ready samples after a write (0 treated as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| timeoutErr | output | 1 | Ready wait expired in the last operation |
| rdData | output | 16 | Word from the last completed read |
| csOut | output | 1 | Device select, active high |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data to the device |
| misoIn | input | 1 | Serial data and ready indication from the device |

## Verification
The in-module assertions watch pin-level rules on every cycle. They check that the clock pulses only while select is high, that data holds during every high phase and that select stays low for at least a cycle after it falls. They also check the single-cycle done strobe, that a busy block ignores new requests and that only a write reports a timeout. Frame contents, the order of the write steps, the read data path, the exact phase and wait durations and the timeout behaviour can only be shown by the bench scenarios. In these a behavioural device model decodes each frame and stores written words.

// File: rtl/eeMwPkg.sv
package eeMwPkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_MISC  = 2'b00;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } eeOp_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic  restartDiv;
    logic  latchReq;
    logic  loadFrame;
    eeOp_t frameKind;
    logic  shiftEn;
    logic  captureRd;
  } eeStrobe_t;
endpackage

// File: rtl/eeMwDatapath.sv
module eeMwDatapath
  import eeMwPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DIV_W-1:0]  halfBitDiv,
  input  logic              misoIn,
  output logic              tick,
  output logic              lastBitTick,
  output logic              sclkOut,
  output logic              mosiOut,
  output logic [DATA_W-1:0] rdData
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(CMD_BITS);

  logic [DIV_W-1:0]      divCnt;
  logic [1:0]            phaseQ;
  logic [CNT_W-1:0]      bitsLeft;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     dataQ;

  function automatic logic [FRAME_BITS-1:0] buildFrame(eeOp_t kind,
      logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    case (kind)
      OP_READ:  return {1'b1, OPC_READ, a, {DATA_W{1'b0}}};
      OP_WRITE: return {1'b1, OPC_WRITE, a, d};
      OP_WREN:  return {1'b1, OPC_MISC, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
      default:  return {1'b1, OPC_MISC, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
    endcase
  endfunction

  // phase timebase
  assign tick = (divCnt == '0) && !stb.restartDiv;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (stb.restartDiv || divCnt == '0) divCnt <= halfBitDiv;
    else divCnt <= divCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.latchReq) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  // bit engine: phase 0 low, 1 high, 2 low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= '0;
      bitsLeft <= '0;
      txShift  <= '0;
      rxShift  <= '0;
    end else if (stb.loadFrame) begin
      txShift  <= buildFrame(stb.frameKind, addrQ, dataQ);
      bitsLeft <= (stb.frameKind == OP_WREN || stb.frameKind == OP_WRDIS) ? SHORT_CNT : FULL_CNT;
      phaseQ   <= '0;
    end else if (stb.shiftEn && tick) begin
      if (phaseQ == 2'd1) rxShift <= {rxShift[DATA_W-2:0], misoIn};
      if (phaseQ == 2'd2) begin
        phaseQ   <= '0;
        txShift  <= {txShift[FRAME_BITS-2:0], 1'b0};
        bitsLeft <= bitsLeft - 1'b1;
      end else begin
        phaseQ <= phaseQ + 1'b1;
      end
    end
  end

  assign lastBitTick = stb.shiftEn && tick && (phaseQ == 2'd2) && (bitsLeft == CNT_W'(1));
  assign sclkOut     = stb.shiftEn && (phaseQ == 2'd1);
  assign mosiOut     = stb.shiftEn && txShift[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.captureRd) rdData <= rxShift;
  end

  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut && $past(sclkOut) |-> $stable(mosiOut)); // R3
endmodule

// File: rtl/eeMwCtrl.sv
module eeMwCtrl
  import eeMwPkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [TMO_W-1:0] readyTimeout,
  input  logic             tick,
  input  logic             lastBitTick,
  input  logic             misoIn,
  output eeStrobe_t        stb,
  output logic             csOut,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr
);
  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SHIFT, S_POLL} state_t;

  localparam logic [2:0] STEP_WREN  = 3'd0;
  localparam logic [2:0] STEP_DATA  = 3'd1;
  localparam logic [2:0] STEP_POLL  = 3'd2;
  localparam logic [2:0] STEP_WRDIS = 3'd3;

  state_t           state;
  eeOp_t            opQ;
  logic [2:0]       step;
  logic [TMO_W-1:0] pollCnt;
  logic             finishNow;
  logic             pollNext;
  eeOp_t            nextKind;

  // what follows the current deselect gap
  always_comb begin
    finishNow = 1'b0;
    pollNext  = 1'b0;
    nextKind  = opQ;
    if (opQ == OP_WRITE) begin
      case (step)
        STEP_WREN:  nextKind = OP_WREN;
        STEP_DATA:  nextKind = OP_WRITE;
        STEP_POLL:  pollNext = 1'b1;
        STEP_WRDIS: nextKind = OP_WRDIS;
        default:    finishNow = 1'b1;
      endcase
    end else if (step != 3'd0) begin
      finishNow = 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    stb.frameKind = nextKind;
    case (state)
      S_IDLE: begin
        stb.restartDiv = reqValid;
        stb.latchReq   = reqValid;
      end
      S_GAP:   stb.loadFrame = tick && !finishNow && !pollNext;
      S_SHIFT: begin
        stb.shiftEn   = 1'b1;
        stb.captureRd = lastBitTick && (opQ == OP_READ);
      end
      default: ;
    endcase
  end

  assign csOut      = (state == S_SHIFT) || (state == S_POLL);
  assign busy       = (state != S_IDLE);

  logic errQ;
  assign timeoutErr = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opQ     <= OP_READ;
      step    <= '0;
      pollCnt <= '0;
      errQ    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          opQ   <= eeOp_t'(reqOp);
          step  <= '0;
          errQ  <= 1'b0;
          state <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (finishNow) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (pollNext) begin
            pollCnt <= (readyTimeout == '0) ? TMO_W'(1) : readyTimeout;
            state   <= S_POLL;
          end else begin
            state <= S_SHIFT;
          end
        end
        S_SHIFT: if (lastBitTick) begin
          step  <= step + 1'b1;
          state <= S_GAP;
        end
        S_POLL: if (tick) begin
          if (misoIn) begin
            step  <= step + 1'b1;
            state <= S_GAP;
          end else if (pollCnt <= TMO_W'(1)) begin
            errQ  <= 1'b1;
            step  <= step + 1'b1;
            state <= S_GAP;
          end else begin
            pollCnt <= pollCnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqValid |=> $stable(opQ)); // R1
  AST_ERR_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    done && timeoutErr |-> opQ == OP_WRITE); // R8
endmodule

// File: rtl/eeMwMaster.sv
module eeMwMaster
  import eeMwPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DIV_W-1:0]  halfBitDiv,
  input  logic [TMO_W-1:0]  readyTimeout,
  output logic              busy,
  output logic              done,
  output logic              timeoutErr,
  output logic [DATA_W-1:0] rdData,
  output logic              csOut,
  output logic              sclkOut,
  output logic              mosiOut,
  input  logic              misoIn
);
  eeStrobe_t stb;
  logic      tick;
  logic      lastBitTick;

  eeMwCtrl #(.TMO_W(TMO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .readyTimeout(readyTimeout), .tick(tick), .lastBitTick(lastBitTick),
    .misoIn(misoIn), .stb(stb), .csOut(csOut), .busy(busy), .done(done),
    .timeoutErr(timeoutErr)
  );

  eeMwDatapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .halfBitDiv(halfBitDiv), .misoIn(misoIn), .tick(tick),
    .lastBitTick(lastBitTick), .sclkOut(sclkOut), .mosiOut(mosiOut),
    .rdData(rdData)
  );

  AST_CLOCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> csOut); // R11
  AST_DESELECT_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csOut) |=> !csOut); // R10
endmodule

// File: tb/eeMwMaster_tb_top.sv
`timescale 1ns/1ps
module eeMwMaster_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [7:0]  halfBitDiv = 8'd3;
  logic [15:0] readyTimeout = 16'd1000;
  logic        busy, done, timeoutErr, csOut, sclkOut, mosiOut, misoIn;
  logic [15:0] rdData;

  always #4 clk = ~clk;

  eeMwMaster dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .halfBitDiv(halfBitDiv),
    .readyTimeout(readyTimeout), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .rdData(rdData), .csOut(csOut),
    .sclkOut(sclkOut), .mosiOut(mosiOut), .misoIn(misoIn)
  );

  int total = 0;
  int bad = 0;
  bit finishedF = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  localparam int WBUSY = 40;
  int          cycNow = 0;
  int          busyUntil = 0;
  bit          stuck = 0;
  int          bitM = 0;
  logic [26:0] shM = '0;
  bit          rdActM = 0;
  logic [7:0]  rdAddrM = '0;
  bit          weM = 0;
  logic [15:0] memM [256];
  bit          wrValid [256];
  int          logM [256];
  int          logN = 0;
  // log codes: 1 enable, 2 disable, 3 read, 4 write, 9 malformed

  always @(posedge clk) cycNow++;

  always @(posedge sclkOut or negedge csOut) begin
    if (!csOut) begin
      if (bitM == 11 && shM[10:8] == 3'b100 && shM[7:0] == 8'hFF) begin
        weM = 1; logM[logN % 256] = 1; logN++;
      end else if (bitM == 11 && shM[10:8] == 3'b100 && shM[7:0] == 8'h00) begin
        weM = 0; logM[logN % 256] = 2; logN++;
      end else if (bitM == 27 && shM[26:24] == 3'b110) begin
        logM[logN % 256] = 3; logN++;
      end else if (bitM == 27 && shM[26:24] == 3'b101) begin
        if (weM) begin
          memM[shM[23:16]] = shM[15:0];
          wrValid[shM[23:16]] = 1;
          busyUntil = cycNow + WBUSY;
        end
        logM[logN % 256] = 4; logN++;
      end else if (bitM != 0) begin
        logM[logN % 256] = 9; logN++;
      end
      bitM = 0;
      rdActM = 0;
    end else begin
      shM = {shM[25:0], mosiOut};
      bitM++;
      if (bitM == 11 && shM[10:8] == 3'b110) begin
        rdActM = 1;
        rdAddrM = shM[7:0];
      end
    end
  end

  function automatic logic [15:0] memRead(input logic [7:0] a);
    return wrValid[a] ? memM[a] : (16'h1000 + {8'h00, a});
  endfunction

  assign misoIn = (rdActM && bitM >= 12 && bitM <= 27) ? memRead(rdAddrM)[27 - bitM]
                                                       : (!stuck && cycNow >= busyUntil);

  // ---------------- pin monitors ----------------
  int  hiRun = 0, loRun = 0, sclkRun = 0;
  int  sclkMin = 1000, sclkMax = 0, gapMin = 1000, lastPollLen = 0;
  bit  hiHadSclk = 0, seenHigh = 0, sclkNoCs = 0;
  int  doneCount = 0;

  task automatic resetStats();
    sclkMin = 1000; sclkMax = 0; gapMin = 1000;
  endtask

  always @(negedge clk) begin
    if (done) doneCount++;
    if (sclkOut && !csOut) sclkNoCs = 1;
    if (sclkOut) sclkRun++;
    else if (sclkRun > 0) begin
      if (sclkRun < sclkMin) sclkMin = sclkRun;
      if (sclkRun > sclkMax) sclkMax = sclkRun;
      sclkRun = 0;
    end
    if (csOut) begin
      if (seenHigh && loRun > 0 && loRun < gapMin) gapMin = loRun;
      loRun = 0;
      seenHigh = 1;
      hiRun++;
      if (sclkOut) hiHadSclk = 1;
    end else begin
      if (hiRun > 0 && !hiHadSclk) lastPollLen = hiRun;
      hiRun = 0;
      hiHadSclk = 0;
      loRun++;
    end
  end

  // ---------------- operation driver ----------------
  logic [15:0] lastRd;
  bit          lastErr;
  int          logBase;

  task automatic runOp(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                       input bit poke);
    int cyc = 0;
    @(negedge clk);
    logBase = logN;
    reqValid = 1; reqOp = op; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    while (!done && cyc < 20000) begin
      if (poke && cyc == 5) begin
        reqValid = 1; reqOp = 2'd1; reqAddr = 8'h33; reqWdata = 16'hDEAD;
      end else begin
        reqValid = 0;
      end
      @(negedge clk);
      cyc++;
    end
    reqValid = 0;
    chk(done == 1'b1, "R1 operation completes", done, 1);
    lastRd = rdData;
    lastErr = timeoutErr;
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic checkLog(input logic [1:0] op, input string tag);
    int n = logN - logBase;
    if (op == 2'd1) begin
      chk(n == 3, {tag, " frame count"}, n, 3);
      chk(logM[logBase % 256] == 1 && logM[(logBase+1) % 256] == 4 &&
          logM[(logBase+2) % 256] == 2, {tag, " enable/write/disable order"},
          logM[(logBase+1) % 256], 4);
    end else begin
      int expCode = (op == 2'd0) ? 3 : (op == 2'd2) ? 1 : 2;
      chk(n == 1, {tag, " frame count"}, n, 1);
      chk(logM[logBase % 256] == expCode, {tag, " frame decode"}, logM[logBase % 256], expCode);
    end
  endtask

  // op, addr, wdata, expected read, expected error
  localparam int NV = 9;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 8'h00, 16'h0000, 16'h1000, 1'b0},
    {2'd1, 8'h05, 16'hA5C3, 16'h0000, 1'b0},
    {2'd0, 8'h05, 16'h0000, 16'hA5C3, 1'b0},
    {2'd1, 8'hFF, 16'h8001, 16'h0000, 1'b0},
    {2'd0, 8'hFF, 16'h0000, 16'h8001, 1'b0},
    {2'd0, 8'h80, 16'h0000, 16'h1080, 1'b0},
    {2'd1, 8'h00, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 8'h00, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 8'h05, 16'h0000, 16'hA5C3, 1'b0}
  };

  initial begin
    logic [15:0] holdRd;
    repeat (4) @(negedge clk);
    // reset state (R1)
    chk(csOut == 0 && sclkOut == 0, "R1 reset pins low", {csOut, sclkOut}, 0);
    chk(busy == 0 && done == 0 && timeoutErr == 0, "R1 reset status low",
        {busy, done, timeoutErr}, 0);
    chk(rdData == 16'h0, "R1 reset read data", rdData, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // table walk: R2 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      runOp(VEC[i][42:41], VEC[i][40:33], VEC[i][32:17], 1'b0);
      checkLog(VEC[i][42:41], VEC[i][42:41] == 2'd1 ? "R6" : "R2");
      chk(lastErr == VEC[i][0], "R7 no timeout when ready", lastErr, VEC[i][0]);
      if (VEC[i][42:41] == 2'd0)
        chk(lastRd == VEC[i][16:1], "R4 read data", lastRd, VEC[i][16:1]);
      if (VEC[i][42:41] == 2'd1)
        chk(weM == 0, "R6 writes disabled at end", weM, 0);
    end

    // phase timing and deselect gaps at divider 3 (R3 R10 R11)
    chk(sclkMin == 4 && sclkMax == 4, "R3 clock high length", sclkMax, 4);
    chk(gapMin >= 4, "R10 deselect gap", gapMin, 4);
    chk(sclkNoCs == 0, "R11 clock without select", sclkNoCs, 0);

    // rdData holds across a write (R5)
    holdRd = rdData;
    runOp(2'd1, 8'h44, 16'h1234, 1'b0);
    chk(rdData == holdRd, "R5 read data held", rdData, holdRd);

    // standalone enable / disable frames (R2)
    runOp(2'd2, 8'h12, 16'h0, 1'b0);
    checkLog(2'd2, "R2");
    chk(weM == 1, "R2 enable frame accepted", weM, 1);
    runOp(2'd3, 8'h12, 16'h0, 1'b0);
    checkLog(2'd3, "R2");
    chk(weM == 0, "R2 disable frame accepted", weM, 0);

    // request while busy is ignored (R1)
    doneCount = 0;
    runOp(2'd0, 8'h10, 16'h0, 1'b1);
    chk(doneCount == 1, "R1 single completion", doneCount, 1);
    chk(lastRd == 16'h1010, "R4 read during poke", lastRd, 16'h1010);
    runOp(2'd0, 8'h33, 16'h0, 1'b0);
    chk(lastRd == 16'h1033, "R1 busy request ignored", lastRd, 16'h1033);

    // timeout: device never ready (R7 R8 R9)
    stuck = 1;
    readyTimeout = 16'd6;
    runOp(2'd1, 8'h20, 16'h1111, 1'b0);
    chk(lastErr == 1, "R8 timeout flagged", lastErr, 1);
    chk(lastPollLen == 24, "R7 ready wait length", lastPollLen, 24);
    checkLog(2'd1, "R8");
    chk(weM == 0, "R8 disable still sent", weM, 0);
    repeat (10) @(negedge clk);
    chk(timeoutErr == 1, "R9 error held", timeoutErr, 1);
    readyTimeout = 16'd0;
    runOp(2'd1, 8'h21, 16'h2222, 1'b0);
    chk(lastErr == 1, "R8 zero timeout flagged", lastErr, 1);
    chk(lastPollLen == 4, "R8 zero timeout single sample", lastPollLen, 4);
    stuck = 0;
    readyTimeout = 16'd1000;
    runOp(2'd0, 8'h20, 16'h0, 1'b0);
    chk(lastErr == 0, "R9 error cleared by next request", lastErr, 0);
    chk(lastRd == 16'h1111, "R4 read after timed-out write", lastRd, 16'h1111);

    // fastest divider (R3 R4 R10)
    halfBitDiv = 8'd0;
    resetStats();
    runOp(2'd0, 8'hFF, 16'h0, 1'b0);
    chk(lastRd == 16'h8001, "R4 read at divider 0", lastRd, 16'h8001);
    chk(sclkMin == 1 && sclkMax == 1, "R3 clock high length div0", sclkMax, 1);
    chk(gapMin >= 1, "R10 deselect gap div0", gapMin, 1);

    finishedF = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finishedF) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule